// File: doc/BRIEF.md
# USB Frame-Start Tracker with Interpolation

This block keeps the 11-bit USB frame number and raises a sticky frame-refresh status bit each time that number changes. It runs in one of two modes, chosen by `host_sel`.

In host mode, an internal millisecond timer counts 1 µs ticks and advances the frame number by one at the end of each period. The timer runs only while the software enable `run_en` is 1. In device mode, the block follows the frame numbers carried by received start-of-frame tokens. Once it has seen one good token, an internal interpolation timer fills in a missing token with the next expected frame. A damaged token also produces the next expected frame, so the frame number and the interrupt stay on schedule. Packet decoding and CRC checking happen upstream; this block sees only a strobe, a frame number and a damage flag.

A four-state machine sequences the block:

- **HOST_STOP**: host mode with the enable off. The timer is held at zero.
- **HOST_RUN**: host mode with the enable on. The timer counts.
- **DEV_SEEK**: device mode before the first good token. The timer is held at zero.
- **DEV_LOCK**: device mode after a good token. The timer interpolates.

The transitions are:

- **enable-on** (HOST_STOP to HOST_RUN) and **enable-off** (HOST_RUN to HOST_STOP).
- **to-device** (either host state to DEV_SEEK).
- **lock** (DEV_SEEK to DEV_LOCK, taken on a good token).
- **to-host** (either device state to HOST_RUN or HOST_STOP, chosen by `run_en`).

Every change of state restarts the timer from zero.

Top module: `sof_frame_tracker`

## Requirements
- R1: After reset, `frame_num` is 0, `refresh_flag` is 0 and the machine is in HOST_STOP.
- R2: In host mode with `run_en`=1, `frame_num` increases by one, and `refresh_flag` is set, on every TICKS_PER_FRAME-th `us_tick` pulse.
- R3: In host mode with `run_en`=0, `us_tick` pulses change neither `frame_num` nor `refresh_flag`.
- R4: Taking `run_en` from 0 to 1 in host mode restarts the timer from zero. The first update then comes exactly TICKS_PER_FRAME ticks later, whatever partial count was reached before.
- R5: `frame_num` wraps from 2047 to 0 on an increment.
- R6: In device mode, a good token (`tok_stb`=1, `tok_bad`=0) loads `tok_fnum` into `frame_num`, sets `refresh_flag` and restarts the timer. This holds in both DEV_SEEK and DEV_LOCK.
- R7: In DEV_LOCK, if TICKS_PER_FRAME ticks pass with no token, `frame_num` increases by one and `refresh_flag` is set.
- R8: In DEV_LOCK, a damaged token (`tok_stb`=1, `tok_bad`=1) increases `frame_num` by one, sets `refresh_flag` and restarts the timer.
- R9: In DEV_SEEK, ticks and damaged tokens change neither `frame_num` nor `refresh_flag`.
- R10: In host mode, tokens change neither `frame_num` nor `refresh_flag`.
- R11: `refresh_flag` stays 1 until a `flag_clr` pulse clears it. If a set event falls in the same cycle as `flag_clr`, the set wins and the flag reads 1.
- R12: In DEV_LOCK, a token that arrives in the same cycle as a timer expiry takes priority. Exactly one update is made (load for a good token, +1 for a damaged one), and the timer restarts.
- R13: Switching `host_sel` keeps `frame_num` unchanged and does not set `refresh_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| host_sel | input | 1 | 1 selects host mode, 0 selects device mode |
| run_en | input | 1 | Software enable for host-mode frame counting |
| tok_stb | input | 1 | Start-of-frame token received strobe |
| tok_bad | input | 1 | Received token is damaged (qualifies `tok_stb`) |
| tok_fnum | input | FN_W | Frame number carried by the token |
| flag_clr | input | 1 | Software write of 0 to the refresh status bit |
| frame_num | output | FN_W | Current frame number |
| refresh_flag | output | 1 | Sticky frame-refresh interrupt status |

## Verification
The bench builds the block with TICKS_PER_FRAME set to 8 and FN_W left at 11. A millisecond period therefore takes a handful of ticks, so the exact expiry tick and the timer restarts can be reached within a short run. These include an expiry falling in the same cycle as a token or a flag clear. Keeping FN_W at 11 lets the 2047-to-0 wrap be reached by loading 2046 from a token.

// File: rtl/sof_trk_pkg.sv
package sof_trk_pkg;

    typedef enum logic [1:0] {
        ST_HOST_STOP = 2'd0,
        ST_HOST_RUN  = 2'd1,
        ST_DEV_SEEK  = 2'd2,
        ST_DEV_LOCK  = 2'd3
    } trk_state_e;

endpackage

// File: rtl/sof_ms_timer.sv
module sof_ms_timer #(
    parameter int TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    input  logic tick_i,
    output logic expire_o
);
    localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last  = (cnt_q == LAST);
    assign expire_o = run_i & tick_i & ~clr_i & at_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i && tick_i) begin
            if (at_last) cnt_q <= '0;
            else         cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R2

    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/sof_refresh_flag.sv
module sof_refresh_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (set_i)  flag_q <= 1'b1;
        else if (clr_i)  flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q); // R11

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q); // R11

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q); // R11

endmodule

// File: rtl/sof_frame_seq.sv
module sof_frame_seq
    import sof_trk_pkg::*;
#(
    parameter int FN_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_sel,
    input  logic            run_en,
    input  logic            tok_stb,
    input  logic            tok_bad,
    input  logic [FN_W-1:0] tok_fnum,
    input  logic            tmr_expire,
    output logic            tmr_run,
    output logic            tmr_clr,
    output logic            upd_o,
    output logic [FN_W-1:0] frame_o
);
    trk_state_e      state_q, state_d;
    logic [FN_W-1:0] frame_q, frame_d;
    logic            tok_ok, tok_dmg, in_host;

    assign tok_ok  = tok_stb & ~tok_bad;
    assign tok_dmg = tok_stb &  tok_bad;
    assign in_host = (state_q == ST_HOST_STOP) || (state_q == ST_HOST_RUN);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HOST_STOP;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOST_STOP: begin
                if (!host_sel)   state_d = ST_DEV_SEEK;   // to-device
                else if (run_en) state_d = ST_HOST_RUN;   // enable-on
            end
            ST_HOST_RUN: begin
                if (!host_sel)    state_d = ST_DEV_SEEK;  // to-device
                else if (!run_en) state_d = ST_HOST_STOP; // enable-off
            end
            ST_DEV_SEEK: begin
                if (host_sel)    state_d = run_en ? ST_HOST_RUN : ST_HOST_STOP; // to-host
                else if (tok_ok) state_d = ST_DEV_LOCK;   // lock
            end
            ST_DEV_LOCK: begin
                if (host_sel)    state_d = run_en ? ST_HOST_RUN : ST_HOST_STOP; // to-host
            end
            default: state_d = ST_HOST_STOP;
        endcase
    end

    // outputs: timer control and frame update
    always_comb begin
        tmr_run = (state_q == ST_HOST_RUN) || (state_q == ST_DEV_LOCK);
        tmr_clr = (state_d != state_q)
                || (state_q == ST_HOST_STOP)
                || (state_q == ST_DEV_SEEK)
                || ((state_q == ST_DEV_LOCK) && !host_sel && tok_stb);
        frame_d = frame_q;
        upd_o   = 1'b0;
        unique case (state_q)
            ST_HOST_STOP: ;
            ST_HOST_RUN: begin
                if (host_sel && run_en && tmr_expire) begin
                    frame_d = frame_q + FN_W'(1);
                    upd_o   = 1'b1;
                end
            end
            ST_DEV_SEEK: begin
                if (!host_sel && tok_ok) begin
                    frame_d = tok_fnum;
                    upd_o   = 1'b1;
                end
            end
            ST_DEV_LOCK: begin
                if (!host_sel) begin
                    if (tok_ok) begin
                        frame_d = tok_fnum;
                        upd_o   = 1'b1;
                    end else if (tok_dmg || tmr_expire) begin
                        frame_d = frame_q + FN_W'(1);
                        upd_o   = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) frame_q <= '0;
        else        frame_q <= frame_d;
    end

    assign frame_o = frame_q;

    AST_HOST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOST_RUN && host_sel && run_en && tmr_expire)
        |=> (frame_q == FN_W'($past(frame_q) + FN_W'(1)))); // R2

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOST_STOP) |=> $stable(frame_q)); // R3

    AST_TOKEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_host && !host_sel && tok_ok) |=> (frame_q == $past(tok_fnum))); // R6

    AST_INTERP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEV_LOCK && !host_sel && !tok_stb && tmr_expire)
        |=> (frame_q == FN_W'($past(frame_q) + FN_W'(1)))); // R7

    AST_SEEK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEV_SEEK && !tok_ok) |=> $stable(frame_q)); // R9

    AST_HOST_NO_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_host && host_sel && !tmr_expire) |=> $stable(frame_q)); // R10

    AST_MODE_SWAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_host != host_sel) |=> $stable(frame_q)); // R13

endmodule

// File: rtl/sof_frame_tracker.sv
module sof_frame_tracker #(
    parameter int FN_W            = 11,
    parameter int TICKS_PER_FRAME = 1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            us_tick,
    input  logic            host_sel,
    input  logic            run_en,
    input  logic            tok_stb,
    input  logic            tok_bad,
    input  logic [FN_W-1:0] tok_fnum,
    input  logic            flag_clr,
    output logic [FN_W-1:0] frame_num,
    output logic            refresh_flag
);
    logic tmr_run, tmr_clr, tmr_expire, upd;

    sof_frame_seq #(.FN_W(FN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .run_en     (run_en),
        .tok_stb    (tok_stb),
        .tok_bad    (tok_bad),
        .tok_fnum   (tok_fnum),
        .tmr_expire (tmr_expire),
        .tmr_run    (tmr_run),
        .tmr_clr    (tmr_clr),
        .upd_o      (upd),
        .frame_o    (frame_num)
    );

    sof_ms_timer #(.TICKS(TICKS_PER_FRAME)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (tmr_run),
        .clr_i    (tmr_clr),
        .tick_i   (us_tick),
        .expire_o (tmr_expire)
    );

    sof_refresh_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (upd),
        .clr_i  (flag_clr),
        .flag_o (refresh_flag)
    );

    AST_FLAG_FOLLOWS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_num != $past(frame_num)) |-> refresh_flag); // R11

endmodule

// File: tb/sof_frame_tracker_tb.sv
module sof_frame_tracker_tb;
    localparam int FN_W = 11;
    localparam int T    = 8;

    logic            clk = 1'b0;
    logic            rst_n, us_tick, host_sel, run_en, tok_stb, tok_bad, flag_clr;
    logic [FN_W-1:0] tok_fnum;
    logic [FN_W-1:0] frame_num;
    logic            refresh_flag;

    int vec_n = 0;
    int bad_n = 0;

    always #4 clk = ~clk;

    sof_frame_tracker #(.FN_W(FN_W), .TICKS_PER_FRAME(T)) u_dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .host_sel(host_sel),
        .run_en(run_en), .tok_stb(tok_stb), .tok_bad(tok_bad),
        .tok_fnum(tok_fnum), .flag_clr(flag_clr),
        .frame_num(frame_num), .refresh_flag(refresh_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        vec_n++;
        if (act != exp) begin
            bad_n++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_state(input string req, input int fn, input int fl);
        check({req, " frame"}, int'(frame_num), fn);
        check({req, " flag"}, int'(refresh_flag), fl);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            us_tick = 1'b1; step();
            us_tick = 1'b0; step();
        end
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1; step();
        flag_clr = 1'b0;
    endtask

    task automatic token(input int fn, input logic bad, input logic with_tick);
        tok_stb = 1'b1; tok_bad = bad; tok_fnum = FN_W'(fn); us_tick = with_tick;
        step();
        tok_stb = 1'b0; tok_bad = 1'b0; us_tick = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; us_tick = 0; host_sel = 1; run_en = 0;
        tok_stb = 0; tok_bad = 0; tok_fnum = '0; flag_clr = 0;
        repeat (3) step();
        rst_n = 1'b1; step();
        expect_state("R1 reset", 0, 0);
    endtask

    task automatic t_host();
        ticks(2 * T);
        expect_state("R3 disabled", 0, 0);
        run_en = 1'b1; step();
        ticks(T - 1);
        expect_state("R4 before first period", 0, 0);
        ticks(1);
        expect_state("R2 first period", 1, 1);
        clear_flag(); step();
        check("R11 clear", int'(refresh_flag), 0);
        ticks(T);
        expect_state("R2 second period", 2, 1);
        clear_flag();
        ticks(3);
        run_en = 1'b0; step();
        run_en = 1'b1; step();
        ticks(T - 1);
        expect_state("R4 restart holds", 2, 0);
        ticks(1);
        expect_state("R4 restart period", 3, 1);
        clear_flag();
        token(500, 1'b0, 1'b0); step();
        expect_state("R10 host ignores token", 3, 0);
        run_en = 1'b0; step();
        ticks(T);
        expect_state("R3 disabled again", 3, 0);
    endtask

    task automatic t_device();
        host_sel = 1'b0; step();
        expect_state("R13 to device", 3, 0);
        ticks(2 * T);
        token(0, 1'b1, 1'b0); step();
        expect_state("R9 seek quiet", 3, 0);
        token(100, 1'b0, 1'b0);
        expect_state("R6 first token", 100, 1);
        clear_flag();
        ticks(T - 1);
        token(200, 1'b0, 1'b0);
        expect_state("R6 reload", 200, 1);
        clear_flag();
        ticks(T - 1);
        expect_state("R6 timer restarted", 200, 0);
        ticks(1);
        expect_state("R7 interpolate", 201, 1);
        clear_flag();
        ticks(3);
        token(0, 1'b1, 1'b0);
        expect_state("R8 damaged token", 202, 1);
        clear_flag();
        ticks(T - 1);
        expect_state("R8 timer restarted", 202, 0);
        ticks(1);
        expect_state("R7 after damaged", 203, 1);
    endtask

    task automatic t_collide();
        clear_flag();
        ticks(T - 1);
        token(700, 1'b0, 1'b1);
        expect_state("R12 good token vs expiry", 700, 1);
        ticks(T - 1);
        check("R12 restart after good", int'(frame_num), 700);
        token(0, 1'b1, 1'b1);
        check("R12 damaged vs expiry single step", int'(frame_num), 701);
        ticks(T - 1);
        check("R12 restart after damaged", int'(frame_num), 701);
        ticks(1);
        check("R7 next period", int'(frame_num), 702);
        clear_flag();
        ticks(T - 1);
        us_tick = 1'b1; flag_clr = 1'b1; step();
        us_tick = 1'b0; flag_clr = 1'b0;
        expect_state("R11 set beats clear", 703, 1);
    endtask

    task automatic t_wrap_and_back();
        token(2046, 1'b0, 1'b0);
        check("R6 load 2046", int'(frame_num), 2046);
        ticks(T);
        check("R7 to 2047", int'(frame_num), 2047);
        ticks(T);
        check("R5 wrap", int'(frame_num), 0);
        clear_flag();
        run_en = 1'b1; host_sel = 1'b1; step();
        expect_state("R13 to host", 0, 0);
        ticks(T - 1);
        check("R4 host entry restart", int'(frame_num), 0);
        ticks(1);
        expect_state("R2 after return", 1, 1);
    endtask

    initial begin
        #(200000 * 8);
        bad_n++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_host();
        t_device();
        t_collide();
        t_wrap_and_back();
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    end

endmodule